// File: doc/BRIEF.md
# Virtual Processor Run Controller

This block decides which of a small set of virtual processors are allowed to execute. Software drives it through a narrow register port. Writing a bitmask to the run register starts the selected processors. Writing a bitmask to the stop register halts them. A status register reports which processors are currently running. Each processor gets a level-sensitive halt output and a single-cycle wake pulse that fires only when the processor actually moves from halted to running. Power sequencing, clocking and the processors themselves belong to the surrounding logic.

All three registers can be reached at two aliased windows: a window for the requesting core and a window for another core. Both windows behave the same way. On reset every processor is halted. In the first cycle after reset is released, the parameter `START_MASK` is applied as a run request. A `START_MASK` with bits set at or above `NUM_VP` stops elaboration with an error.

Top module: `vp_run_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every `vp_halt` bit is 1 and every `vp_wake` bit is 0 after that edge, and `rsp_rdata` is zero.
- R2: In the first cycle after `rst` is released, `START_MASK` (default 1) is treated as a run request. After the next edge, the processors in the mask are running and each gets one wake pulse.
- R3: A write to the run register (offset 0x00) starts each processor whose data bit is 1 and which is halted. After the next edge its halt bit is 0 and its wake bit is 1 for exactly one cycle.
- R4: A run bit for a processor that is already running changes nothing and produces no wake pulse.
- R5: A write to the stop register (offset 0x08) halts each running processor whose data bit is 1, starting after the next edge. A stop bit for a halted processor has no effect and never produces a wake pulse.
- R6: A stop write in the first cycle after reset release cancels the pending start request for the selected processors: they get no wake pulse and stay halted.
- R7: Run and stop write data bits at positions `NUM_VP` and above are ignored.
- R8: A read of the status register (offset 0x10) returns the running mask, zero-extended, on `rsp_rdata` one cycle after the request. Bit i is processor i. `rsp_rdata` holds its value until the next read.
- R9: Offsets 0x20 (run), 0x28 (stop) and 0x30 (status) behave exactly like 0x00, 0x08 and 0x10. Address bit 5 selects the window.
- R10: A read from any other address returns zero, and so does a read of the run or stop register. A write to any other address changes no state. Every address with bit 7 or bit 6 set is unmapped.
- R11: `vp_halt[i]` is always the inverse of processor i's running bit as seen through the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the access |
| req_wdata | input | DATA_W | Write data (bitmask) |
| rsp_rdata | output | DATA_W | Read data, valid the cycle after a read request |
| vp_halt | output | NUM_VP | Per-processor halt level |
| vp_wake | output | NUM_VP | Per-processor one-cycle wake pulse |

## Verification
The assertions assume that each cycle carries at most one access, so run and stop for the same processor never arrive together. They also assume that `req_write` is meaningful only while `req_valid` is high. The stimulus keeps to these assumptions by construction: every access is a single-cycle pulse of `req_valid` with one address. The stimulus also includes a stop request that is held across reset release, so that it lands in the start-up cycle. Addresses are drawn from the mapped offsets in both windows and from a set of unaligned and out-of-range addresses. Write data sets bits above the processor count so that masking is exercised.

// File: rtl/vprc_pkg.sv
package vprc_pkg;

    localparam int unsigned ADDR_W = 8;

    // Word offsets inside one window; address bit 5 picks the window
    localparam logic [4:0] OFS_RUN    = 5'h00;
    localparam logic [4:0] OFS_STOP   = 5'h08;
    localparam logic [4:0] OFS_STATUS = 5'h10;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_RUN    = 2'd1,
        SEL_STOP   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     valid;
        logic     write;
        reg_sel_e sel;
    } reg_cmd_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[7:6] == 2'b00) begin
            case (a[4:0])
                OFS_RUN:    s = SEL_RUN;
                OFS_STOP:   s = SEL_STOP;
                OFS_STATUS: s = SEL_STATUS;
                default:    s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic bit start_fits(input logic [63:0] m, input int unsigned n);
        if (n >= 64) return 1'b1;
        return (m >> n) == 64'd0;
    endfunction

endpackage

// File: rtl/vprc_decode.sv
module vprc_decode
    import vprc_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output reg_cmd_t          cmd
);

    always_comb begin
        cmd.valid = req_valid;
        cmd.write = req_write;
        cmd.sel   = req_valid ? decode_offset(req_addr) : SEL_NONE;
    end

endmodule

// File: rtl/vprc_bitmask.sv
module vprc_bitmask
    import vprc_pkg::*;
#(
    parameter int unsigned NUM_VP = 6,
    parameter int unsigned DATA_W = 32
) (
    input  reg_cmd_t            cmd,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                boot,
    input  logic [NUM_VP-1:0]   start_bits,
    output logic [NUM_VP-1:0]   run_bits,
    output logic [NUM_VP-1:0]   stop_bits
);

    logic [NUM_VP-1:0] wr_bits;
    assign wr_bits = wdata[NUM_VP-1:0];

    generate
        if (DATA_W > NUM_VP) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^wdata[DATA_W-1:NUM_VP];
        end
    endgenerate

    always_comb begin
        run_bits  = boot ? start_bits : '0;
        stop_bits = '0;
        if (cmd.valid && cmd.write) begin
            case (cmd.sel)
                SEL_RUN:  run_bits  = run_bits | wr_bits;
                SEL_STOP: stop_bits = wr_bits;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/vprc_vp_slot.sv
module vprc_vp_slot (
    input  logic clk,
    input  logic rst,
    input  logic run_req,
    input  logic stop_req,
    output logic running_o,
    output logic wake_o,
    output logic halt_o
);

    logic running_q;
    logic wake_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            wake_q    <= 1'b0;
        end else if (stop_req) begin
            running_q <= 1'b0;
            wake_q    <= 1'b0;
        end else if (run_req && !running_q) begin
            running_q <= 1'b1;
            wake_q    <= 1'b1;
        end else begin
            wake_q    <= 1'b0;
        end
    end

    assign running_o = running_q;
    assign wake_o    = wake_q;
    assign halt_o    = ~running_q;

    // R3: a wake pulse only accompanies a running processor
    p_wake_running_r3: assert property (@(posedge clk) disable iff (rst)
        wake_q |-> running_q)
        else $error("p_wake_running_r3");

    // R3: wake lasts one cycle
    p_wake_single_r3: assert property (@(posedge clk) disable iff (rst)
        wake_q |=> !wake_q)
        else $error("p_wake_single_r3");

    // R3: a run request without stop leaves the processor running
    p_run_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (run_req && !stop_req) |=> running_q)
        else $error("p_run_sets_r3");

    // R4: no wake for an already running processor
    p_no_rewake_r4: assert property (@(posedge clk) disable iff (rst)
        running_q |=> !wake_q)
        else $error("p_no_rewake_r4");

    // R5, R6: stop halts and suppresses any wake
    p_stop_halts_r5: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> (!running_q && !wake_q))
        else $error("p_stop_halts_r5");

endmodule

// File: rtl/vprc_readback.sv
module vprc_readback
    import vprc_pkg::*;
#(
    parameter int unsigned NUM_VP = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_cmd_t          cmd,
    input  logic [NUM_VP-1:0] running,
    output logic [DATA_W-1:0] rdata
);

    logic is_read;
    assign is_read = cmd.valid && !cmd.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (is_read) begin
            rdata <= (cmd.sel == SEL_STATUS) ? DATA_W'(running) : '0;
        end
    end

    // R8: status read returns the mask seen at request time
    p_status_read_r8: assert property (@(posedge clk) disable iff (rst)
        (is_read && cmd.sel == SEL_STATUS) |=> (rdata == DATA_W'($past(running))))
        else $error("p_status_read_r8");

    // R8: data holds between reads
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !is_read |=> $stable(rdata))
        else $error("p_rdata_hold_r8");

    // R10: other reads give zero
    p_other_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (is_read && cmd.sel != SEL_STATUS) |=> (rdata == '0))
        else $error("p_other_read_zero_r10");

endmodule

// File: rtl/vp_run_ctrl.sv
module vp_run_ctrl
    import vprc_pkg::*;
#(
    parameter int unsigned NUM_VP     = 6,
    parameter int unsigned DATA_W     = 32,
    parameter logic [63:0] START_MASK = 64'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [NUM_VP-1:0] vp_halt,
    output logic [NUM_VP-1:0] vp_wake
);

    localparam logic [NUM_VP-1:0] START_BITS = START_MASK[NUM_VP-1:0];

    generate
        if (!start_fits(START_MASK, NUM_VP)) begin : g_bad_start
            $error("START_MASK has bits at or above NUM_VP");
        end
        if (NUM_VP > DATA_W || NUM_VP == 0) begin : g_bad_count
            $error("NUM_VP must be between 1 and DATA_W");
        end
    endgenerate

    // Start-up request: live for the first cycle after reset release
    logic boot_q;
    always_ff @(posedge clk) begin
        if (rst) boot_q <= 1'b1;
        else     boot_q <= 1'b0;
    end

    reg_cmd_t          cmd;
    logic [NUM_VP-1:0] run_bits;
    logic [NUM_VP-1:0] stop_bits;
    logic [NUM_VP-1:0] running;

    vprc_decode u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .cmd       (cmd)
    );

    vprc_bitmask #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) u_bitmask (
        .cmd        (cmd),
        .wdata      (req_wdata),
        .boot       (boot_q),
        .start_bits (START_BITS),
        .run_bits   (run_bits),
        .stop_bits  (stop_bits)
    );

    generate
        for (genvar i = 0; i < NUM_VP; i++) begin : g_slot
            vprc_vp_slot u_slot (
                .clk       (clk),
                .rst       (rst),
                .run_req   (run_bits[i]),
                .stop_req  (stop_bits[i]),
                .running_o (running[i]),
                .wake_o    (vp_wake[i]),
                .halt_o    (vp_halt[i])
            );
        end
    endgenerate

    vprc_readback #(.NUM_VP(NUM_VP), .DATA_W(DATA_W)) u_readback (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .running (running),
        .rdata   (rsp_rdata)
    );

    // R2: start-up request wakes only processors in the start mask
    p_boot_wake_r2: assert property (@(posedge clk) disable iff (rst)
        (boot_q && !(req_valid && req_write)) |=> (vp_wake == START_BITS))
        else $error("p_boot_wake_r2");

    // R10: unmapped writes leave every processor state alone
    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && cmd.sel == SEL_NONE && !boot_q)
            |=> ($stable(vp_halt) && vp_wake == '0))
        else $error("p_unmapped_write_r10");

endmodule

// File: tb/test_vp_run_ctrl.sv
`timescale 1ns/1ps
module test_vp_run_ctrl;

    localparam int NV = 6;
    localparam logic [5:0] START = 6'h01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = 8'h00;
    logic [31:0] req_wdata = 32'h0;
    logic [31:0] rsp_rdata;
    logic [NV-1:0] vp_halt;
    logic [NV-1:0] vp_wake;

    always #4 clk = ~clk;

    vp_run_ctrl #(.NUM_VP(NV), .DATA_W(32), .START_MASK(64'h1)) i_vp_run_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .vp_halt(vp_halt), .vp_wake(vp_wake)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    bit m_live = 0;

    // Behavioural reference
    logic [5:0]  m_run, m_wake;
    logic [31:0] m_rdata;
    bit          m_boot;

    function automatic int kind(input logic [7:0] a);
        case (a)
            8'h00, 8'h20: return 1;
            8'h08, 8'h28: return 2;
            8'h10, 8'h30: return 3;
            default:      return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [5:0] rb, sb;
        if (rst) begin
            m_run = 0; m_wake = 0; m_rdata = 0; m_boot = 1;
        end else begin
            rb = m_boot ? START : 6'h0;
            sb = 6'h0;
            if (req_valid && req_write) begin
                if (kind(req_addr) == 1) rb = rb | req_wdata[5:0];
                else if (kind(req_addr) == 2) sb = req_wdata[5:0];
            end
            if (req_valid && !req_write)
                m_rdata = (kind(req_addr) == 3) ? {26'h0, m_run} : 32'h0;
            m_wake = rb & ~m_run & ~sb;
            m_run  = (m_run | rb) & ~sb;
            m_boot = 0;
        end
        m_live = 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (m_live && !done) begin
            chk(vp_halt == ~m_run, "R11 halt vs model", {26'h0, vp_halt}, {26'h0, ~m_run});
            chk(vp_wake == m_wake, "R3 wake vs model", {26'h0, vp_wake}, {26'h0, m_wake});
            chk(rsp_rdata == m_rdata, "R8 rdata vs model", rsp_rdata, m_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic expect_run(input logic [5:0] r, input logic [5:0] w, input string tag);
        chk(vp_halt == ~r, tag, {26'h0, vp_halt}, {26'h0, ~r});
        chk(vp_wake == w, tag, {26'h0, vp_wake}, {26'h0, w});
    endtask

    task automatic summary;
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_run(6'h00, 6'h00, "R1 reset halts");
        chk(rsp_rdata == 0, "R1 reset rdata", rsp_rdata, 0);
        rst = 0;
        @(negedge clk);
        // R2 start mask applied
        expect_run(6'h01, 6'h01, "R2 start mask");
        @(negedge clk);
        expect_run(6'h01, 6'h00, "R2 wake one cycle");
        rd(8'h10);
        chk(rsp_rdata == 32'h1, "R2 status after start", rsp_rdata, 32'h1);

        wr(8'h00, 32'h06);
        expect_run(6'h07, 6'h06, "R3 run wake");
        @(negedge clk);
        expect_run(6'h07, 6'h00, "R3 wake ends");
        wr(8'h00, 32'h03);
        expect_run(6'h07, 6'h00, "R4 already running");

        wr(8'h08, 32'h05);
        expect_run(6'h02, 6'h00, "R5 stop");
        wr(8'h08, 32'h01);
        expect_run(6'h02, 6'h00, "R5 stop of halted");

        wr(8'h00, 32'hC8);
        expect_run(6'h0A, 6'h08, "R7 high bits ignored run");
        wr(8'h08, 32'hFFFF_FFC0);
        expect_run(6'h0A, 6'h00, "R7 high bits ignored stop");

        wr(8'h20, 32'h10);
        expect_run(6'h1A, 6'h10, "R9 alias run");
        wr(8'h28, 32'h02);
        expect_run(6'h18, 6'h00, "R9 alias stop");
        rd(8'h30);
        chk(rsp_rdata == 32'h18, "R9 alias status", rsp_rdata, 32'h18);
        rd(8'h10);
        chk(rsp_rdata == 32'h18, "R8 status", rsp_rdata, 32'h18);
        repeat (3) @(negedge clk);
        chk(rsp_rdata == 32'h18, "R8 hold", rsp_rdata, 32'h18);

        wr(8'h04, 32'h3F);
        wr(8'h18, 32'h3F);
        wr(8'h40, 32'h3F);
        wr(8'h48, 32'h3F);
        wr(8'h38, 32'h3F);
        expect_run(6'h18, 6'h00, "R10 unmapped writes");
        rd(8'h00);
        chk(rsp_rdata == 0, "R10 read run reg", rsp_rdata, 0);
        rd(8'h50);
        chk(rsp_rdata == 0, "R10 read unmapped", rsp_rdata, 0);
        rd(8'h28);
        chk(rsp_rdata == 0, "R10 read stop alias", rsp_rdata, 0);

        // R6: stop held across reset release
        @(negedge clk);
        rst = 1;
        req_valid = 1; req_write = 1; req_addr = 8'h08; req_wdata = 32'h01;
        @(negedge clk);
        expect_run(6'h00, 6'h00, "R1 reset mid-run");
        rst = 0;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        expect_run(6'h00, 6'h00, "R6 stop cancels start");
        rd(8'h10);
        chk(rsp_rdata == 0, "R6 status", rsp_rdata, 0);

        // Mixed traffic against the reference
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            case ($urandom_range(0, 9))
                0: a = 8'h00; 1: a = 8'h08; 2: a = 8'h10; 3: a = 8'h20;
                4: a = 8'h28; 5: a = 8'h30; 6: a = 8'h04; 7: a = 8'h18;
                8: a = 8'h40; default: a = 8'h38;
            endcase
            if ($urandom_range(0, 2) == 0) rd(a);
            else wr(a, $urandom);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        @(negedge clk);
        summary();
    end

endmodule